// File: doc/BRIEF.md
# External Bus Area Controller

This block turns single requests from an on-chip master into timed cycles on an external memory bus. The external address space is cut into eight equal areas, selected by the three most significant address bits. Each area gets its own active-low chip select and its own timing profile: data bus width (8 or 16 bits), a short two-state or long three-state access, and, for long accesses, up to three extra wait states. Area 0 can also serve a burst-capable ROM. After the first read of a burst block, further reads in the same block take one or two states instead of the full access.

A 16-bit request aimed at an 8-bit area is split into two byte cycles, and a single completion is returned. An optional dead cycle, with every chip select released, is placed after a read when the next access is a read to another area, or when it is a write. Both cases have their own enable. The master presents a request and holds it until the controller takes it. The controller answers with a one-cycle ready pulse that carries the read data.

Top module: `ebus_area_ctrl`

## Requirements
- R1: The area is `req_addr[23:21]`. During every access state, `ext_cs_n` bit *area* is low and the other seven are high. Outside access states all eight are high. After reset all selects and both strobes are high and `req_ready` is low.
- R2: An area whose `cfg_three` bit is 0 completes each byte cycle in exactly 2 states. Its wait count has no effect.
- R3: An area whose `cfg_three` bit is 1 completes each byte cycle in 3 + W states. W is the 2-bit field `cfg_wait[2*area+1:2*area]`.
- R4: `req_ready` is high for exactly one cycle, in the cycle after the last access state. For a 16-bit request `req_rdata` is {byte at the even address, byte at the odd address}. For a byte request it is {8'h00, byte}. A 16-bit area returns the even byte on `ext_din[15:8]` and the odd byte on `ext_din[7:0]`. An 8-bit area uses `ext_din[7:0]`.
- R5: A 16-bit request to an area whose `cfg_wide` bit is 0 runs two byte cycles, first at the even address and then at the odd one, each with full timing. It gives a single ready.
- R6: `ext_rd_n` is low in every state of a read. `ext_wr_n` is high in the first state of each write byte cycle and low in its remaining states. Write data appears as the full word (16-bit request to a 16-bit area) or as the selected byte copied onto both lanes. For a split 16-bit write, the upper byte is sent at the even address.
- R7: With `cfg_burst_en` set, an area 0 read that directly follows an area 0 read within the same 16-byte aligned block takes 1 state, or 2 states when `cfg_burst_two` is set.
- R8: A read in a different 16-byte block, a write, any access outside area 0, or a cleared `cfg_burst_en` ends the burst. The next area 0 read then uses its full R2/R3 timing.
- R9: With `cfg_gap_rr` set, a read that follows a read to a different area is preceded by one cycle with all selects and strobes high. A read to the same area gets no such cycle.
- R10: With `cfg_gap_rw` set, a write that follows a read is preceded by one such cycle. A write that follows a write gets none.
- R11: Address and chip select do not change between the states of one byte cycle, wait states included.
- R12: A 16-bit request with an odd `req_addr` is carried out at the even address just below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present, held until taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data (byte in [7:0]) |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with req_ready |
| cfg_wide | input | 8 | Per area: 1 = 16-bit bus |
| cfg_three | input | 8 | Per area: 1 = three-state access |
| cfg_wait | input | 16 | Per area 2-bit wait count |
| cfg_burst_en | input | 1 | Burst ROM timing for area 0 |
| cfg_burst_two | input | 1 | Burst follow-on takes 2 states |
| cfg_gap_rr | input | 1 | Dead cycle on read to other-area read |
| cfg_gap_rw | input | 1 | Dead cycle on read to write |
| ext_addr | output | 24 | External address |
| ext_cs_n | output | 8 | Active-low chip select per area |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_dout | output | 16 | Write data to the bus |
| ext_dout_en | output | 1 | Drive enable for ext_dout |
| ext_din | input | 16 | Read data from the bus |

## Verification
The bench builds the block with its default parameters: a 24-bit address, eight areas, 2-bit wait fields, 16-byte burst blocks, and the area 0 burst variant switched on. With 2-bit wait fields every wait count from 0 to 3 appears under random configuration. With 16-byte blocks, random offsets inside a 48-byte window land both in and out of the current burst block. This means burst continuation and burst restart both occur often. Because the configuration changes between random phases, the R9/R10 dead cycle is seen both enabled and disabled. The same holds for both bus widths in every area.

// File: rtl/ebus_area_pkg.sv
`timescale 1ns/1ps
package ebus_area_pkg;

   localparam int EBUS_DATA_W = 16;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GAP  = 2'd1,
      ST_ACC  = 2'd2
   } ebus_state_e;

endpackage

// File: rtl/ebus_area_sel.sv
`timescale 1ns/1ps
module ebus_area_sel #(
   parameter int ADDR_W    = 24,
   parameter int AREA_BITS = 3,
   parameter int WAIT_W    = 2,
   localparam int N_AREAS  = 1 << AREA_BITS,
   localparam int AREA_LSB = ADDR_W - AREA_BITS
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      active,
   input  logic [N_AREAS-1:0]        cfg_wide,
   input  logic [N_AREAS-1:0]        cfg_three,
   input  logic [N_AREAS*WAIT_W-1:0] cfg_wait,
   output logic [AREA_BITS-1:0]      area,
   output logic                      wide,
   output logic                      three,
   output logic [WAIT_W-1:0]         waitc,
   output logic [N_AREAS-1:0]        cs_n
);

   assign area  = addr[AREA_LSB +: AREA_BITS];
   assign wide  = cfg_wide[area];
   assign three = cfg_three[area];
   assign waitc = cfg_wait[int'(area)*WAIT_W +: WAIT_W];

   for (genvar i = 0; i < N_AREAS; i++) begin : g_cs
      assign cs_n[i] = !(active && (area == AREA_BITS'(i)));
   end

endmodule

// File: rtl/ebus_cycle_len.sv
`timescale 1ns/1ps
module ebus_cycle_len #(
   parameter int  WAIT_W      = 2,
   parameter bit  BURST_AREA0 = 1'b1,
   localparam int LEN_W       = $clog2(4 + (1 << WAIT_W))
) (
   input  logic              three,
   input  logic [WAIT_W-1:0] waitc,
   input  logic              cont,
   input  logic              burst_two,
   output logic [LEN_W-1:0]  len
);

   logic [LEN_W-1:0] base_len;

   assign base_len = three ? (LEN_W'(3) + LEN_W'(waitc)) : LEN_W'(2);

   if (BURST_AREA0) begin : g_burst
      assign len = cont ? (burst_two ? LEN_W'(2) : LEN_W'(1)) : base_len;
   end else begin : g_plain
      logic unused_burst;
      assign unused_burst = cont ^ burst_two;
      assign len = base_len;
   end

endmodule

// File: rtl/ebus_lane.sv
`timescale 1ns/1ps
module ebus_lane (
   input  logic        wide,
   input  logic        word,
   input  logic        a0,
   input  logic [15:0] wbuf,
   input  logic [15:0] din,
   input  logic [7:0]  rhold,
   output logic [15:0] dout,
   output logic [15:0] rword
);

   logic [7:0] wbyte;
   logic [7:0] rbyte;

   always_comb begin
      if (word) wbyte = a0 ? wbuf[7:0] : wbuf[15:8];
      else      wbyte = wbuf[7:0];
      dout = (wide && word) ? wbuf : {wbyte, wbyte};
   end

   always_comb begin
      rbyte = (wide && !a0) ? din[15:8] : din[7:0];
      if (word) rword = wide ? din : {rhold, din[7:0]};
      else      rword = {8'h00, rbyte};
   end

endmodule

// File: rtl/ebus_area_ctrl.sv
`timescale 1ns/1ps
module ebus_area_ctrl
   import ebus_area_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int AREA_BITS   = 3,
   parameter int WAIT_W      = 2,
   parameter int BURST_BLK_W = 4,
   parameter bit BURST_AREA0 = 1'b1,
   localparam int N_AREAS    = 1 << AREA_BITS,
   localparam int AREA_LSB   = ADDR_W - AREA_BITS,
   localparam int LEN_W      = $clog2(4 + (1 << WAIT_W)),
   localparam int DW         = EBUS_DATA_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic                      req_word,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [DW-1:0]             req_wdata,
   output logic                      req_ready,
   output logic [DW-1:0]             req_rdata,
   input  logic [N_AREAS-1:0]        cfg_wide,
   input  logic [N_AREAS-1:0]        cfg_three,
   input  logic [N_AREAS*WAIT_W-1:0] cfg_wait,
   input  logic                      cfg_burst_en,
   input  logic                      cfg_burst_two,
   input  logic                      cfg_gap_rr,
   input  logic                      cfg_gap_rw,
   output logic [ADDR_W-1:0]         ext_addr,
   output logic [N_AREAS-1:0]        ext_cs_n,
   output logic                      ext_rd_n,
   output logic                      ext_wr_n,
   output logic [DW-1:0]             ext_dout,
   output logic                      ext_dout_en,
   input  logic [DW-1:0]             ext_din
);

   if (AREA_BITS < 1 || AREA_BITS > 4) begin : g_chk_area
      $error("AREA_BITS out of range");
   end
   if (WAIT_W < 1 || WAIT_W > 4) begin : g_chk_wait
      $error("WAIT_W out of range");
   end
   if (ADDR_W < AREA_BITS + BURST_BLK_W + 1) begin : g_chk_addr
      $error("ADDR_W too small for areas and burst block");
   end

   ebus_state_e              st_q;
   logic [ADDR_W-1:0]        addr_q;
   logic                     we_q, word_q;
   logic [DW-1:0]            wbuf_q;
   logic [LEN_W-1:0]         phase_q;
   logic [7:0]               rhold_q;
   logic                     ready_q;
   logic [DW-1:0]            rdata_q;
   logic                     h_valid_q, h_read_q, h_burst_q;
   logic [AREA_BITS-1:0]     h_area_q;
   logic [ADDR_W-BURST_BLK_W-1:0] h_blk_q;

   logic [AREA_BITS-1:0]     cur_area, req_area;
   logic                     cur_wide, cur_three;
   logic [WAIT_W-1:0]        cur_wait;
   logic [LEN_W-1:0]         len;
   logic                     cont, acc, last_st, more, take, need_gap;
   logic [DW-1:0]            rword;

   assign acc = (st_q == ST_ACC);

   ebus_area_sel #(.ADDR_W(ADDR_W), .AREA_BITS(AREA_BITS), .WAIT_W(WAIT_W)) u_sel (
      .addr(addr_q), .active(acc), .cfg_wide(cfg_wide), .cfg_three(cfg_three),
      .cfg_wait(cfg_wait), .area(cur_area), .wide(cur_wide), .three(cur_three),
      .waitc(cur_wait), .cs_n(ext_cs_n)
   );

   if (BURST_AREA0) begin : g_cont
      assign cont = cfg_burst_en && h_valid_q && h_burst_q && !we_q &&
                    (cur_area == '0) &&
                    (addr_q[ADDR_W-1:BURST_BLK_W] == h_blk_q);
   end else begin : g_nocont
      assign cont = 1'b0;
   end

   ebus_cycle_len #(.WAIT_W(WAIT_W), .BURST_AREA0(BURST_AREA0)) u_len (
      .three(cur_three), .waitc(cur_wait), .cont(cont),
      .burst_two(cfg_burst_two), .len(len)
   );

   ebus_lane u_lane (
      .wide(cur_wide), .word(word_q), .a0(addr_q[0]), .wbuf(wbuf_q),
      .din(ext_din), .rhold(rhold_q), .dout(ext_dout), .rword(rword)
   );

   assign req_area = req_addr[AREA_LSB +: AREA_BITS];
   assign take     = (st_q == ST_IDLE) && req_valid && !ready_q;
   assign need_gap = h_valid_q && h_read_q &&
                     (req_write ? cfg_gap_rw : (cfg_gap_rr && (req_area != h_area_q)));
   assign last_st  = acc && (phase_q == len - LEN_W'(1));
   assign more     = word_q && !cur_wide && !addr_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         we_q      <= 1'b0;
         word_q    <= 1'b0;
         wbuf_q    <= '0;
         phase_q   <= '0;
         rhold_q   <= '0;
         ready_q   <= 1'b0;
         rdata_q   <= '0;
         h_valid_q <= 1'b0;
         h_read_q  <= 1'b0;
         h_burst_q <= 1'b0;
         h_area_q  <= '0;
         h_blk_q   <= '0;
      end else begin
         ready_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (take) begin
                  addr_q  <= req_word ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
                  we_q    <= req_write;
                  word_q  <= req_word;
                  wbuf_q  <= req_wdata;
                  phase_q <= '0;
                  st_q    <= need_gap ? ST_GAP : ST_ACC;
               end
            end
            ST_GAP: st_q <= ST_ACC;
            ST_ACC: begin
               if (last_st) begin
                  h_valid_q <= 1'b1;
                  h_read_q  <= !we_q;
                  h_area_q  <= cur_area;
                  h_burst_q <= !we_q && (cur_area == '0) && cfg_burst_en;
                  h_blk_q   <= addr_q[ADDR_W-1:BURST_BLK_W];
                  phase_q   <= '0;
                  if (more) begin
                     addr_q[0] <= 1'b1;
                     rhold_q   <= ext_din[7:0];
                  end else begin
                     st_q    <= ST_IDLE;
                     ready_q <= 1'b1;
                     if (!we_q) rdata_q <= rword;
                  end
               end else begin
                  phase_q <= phase_q + LEN_W'(1);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = ready_q;
   assign req_rdata   = rdata_q;
   assign ext_addr    = addr_q;
   assign ext_rd_n    = !(acc && !we_q);
   assign ext_wr_n    = !(acc && we_q && (phase_q != '0));
   assign ext_dout_en = acc && we_q;

   // Assertions
   p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ext_cs_n));
   p_ready_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);
   p_no_dual_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ext_rd_n && !ext_wr_n));
   p_wr_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && phase_q == '0) |-> ext_wr_n);
   p_one_state_area0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && len == LEN_W'(1)) |-> (!ext_cs_n[0] && !ext_rd_n));
   p_gap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_GAP) |-> (&ext_cs_n && ext_rd_n && ext_wr_n));
   p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && phase_q != '0) |-> ($stable(ext_addr) && $stable(ext_cs_n)));

endmodule

// File: tb/ebus_area_ctrl_test.sv
`timescale 1ns/1ps
module ebus_area_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic [15:0] req_rdata;
   logic [7:0]  cw = '0, c3 = '0;
   logic [15:0] cwt = '0;
   logic        ben = 1'b0, btwo = 1'b0, grr = 1'b0, grw = 1'b0;
   logic [23:0] ext_addr;
   logic [7:0]  ext_cs_n;
   logic        ext_rd_n, ext_wr_n, ext_dout_en;
   logic [15:0] ext_dout, ext_din;

   int tests = 0, fails = 0;
   logic        mv = 1'b0, mrd = 1'b0, mburst = 1'b0;
   int          marea = 0;
   logic [19:0] mblk = '0;

   always #2.5 clk = ~clk;

   ebus_area_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .req_rdata(req_rdata), .cfg_wide(cw),
      .cfg_three(c3), .cfg_wait(cwt), .cfg_burst_en(ben), .cfg_burst_two(btwo),
      .cfg_gap_rr(grr), .cfg_gap_rw(grw), .ext_addr(ext_addr),
      .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
      .ext_dout(ext_dout), .ext_dout_en(ext_dout_en), .ext_din(ext_din)
   );

   function automatic logic [7:0] mem_byte(input logic [23:0] a);
      return a[7:0] ^ 8'h5A ^ {a[23:21], 5'b0};
   endfunction

   always_comb begin
      if (cw[ext_addr[23:21]])
         ext_din = {mem_byte({ext_addr[23:1], 1'b0}), mem_byte({ext_addr[23:1], 1'b1})};
      else
         ext_din = {8'hEE, mem_byte(ext_addr)};
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic do_txn(input logic we, input logic word, input logic [23:0] addr,
                         input logic [15:0] wd, input string tag);
      logic [23:0] a0, ba, first_a, last_a;
      logic [15:0] exp_rd, cap;
      logic [7:0]  exp_cs;
      int area, nbc, exp_states, exp_gap, len, cnt, act, gapc, rdc, wrc;
      bit cont, cs_bad, seen;
      a0 = word ? {addr[23:1], 1'b0} : addr;
      area = int'(a0[23:21]);
      exp_cs = ~(8'b1 << area);
      exp_gap = (mv && mrd && (we ? grw : (grr && area != marea))) ? 1 : 0;
      nbc = (word && !cw[area]) ? 2 : 1;
      exp_states = 0;
      for (int k = 0; k < nbc; k++) begin
         ba = (k == 1) ? {a0[23:1], 1'b1} : a0;
         cont = ben && mburst && !we && area == 0 && (ba[23:4] == mblk);
         if (cont) len = btwo ? 2 : 1;
         else if (c3[area]) len = 3 + int'(cwt[area*2 +: 2]);
         else len = 2;
         exp_states += len;
         mv = 1'b1; mrd = !we; marea = area;
         mburst = !we && area == 0 && ben; mblk = ba[23:4];
      end
      exp_rd = word ? {mem_byte(a0), mem_byte({a0[23:1], 1'b1})} : {8'h00, mem_byte(a0)};
      req_valid = 1'b1; req_write = we; req_word = word; req_addr = addr; req_wdata = wd;
      cnt = 0; act = 0; gapc = 0; rdc = 0; wrc = 0; cs_bad = 0; seen = 0;
      cap = '0; first_a = '0; last_a = '0;
      forever begin
         @(posedge clk); @(negedge clk);
         cnt++;
         if (cnt == 1) req_valid = 1'b0;
         if (ext_cs_n != 8'hFF) begin
            act++;
            if (ext_cs_n != exp_cs) cs_bad = 1;
            if (!seen) first_a = ext_addr;
            seen = 1; last_a = ext_addr;
         end
         if (!ext_rd_n) rdc++;
         if (!ext_wr_n) begin
            wrc++;
            if (cw[area] && word) cap = ext_dout;
            else if (word) begin
               if (ext_addr[0]) cap[7:0] = ext_dout[7:0]; else cap[15:8] = ext_dout[7:0];
            end else cap = {8'h00, (cw[area] && !ext_addr[0]) ? ext_dout[15:8] : ext_dout[7:0]};
         end
         if (req_ready) break;
         if (ext_cs_n == 8'hFF) gapc++;
         if (cnt > 60) break;
      end
      chk(req_ready, "R4", "ready seen", int'(req_ready), 1);
      chk(!cs_bad, "R1", "chip select pattern", 0, int'(exp_cs));
      chk(act == exp_states, tag, "access states", act, exp_states);
      chk(gapc == exp_gap, we ? "R10" : "R9", "idle cycles", gapc, exp_gap);
      chk(cnt == exp_states + exp_gap + 1, "R4", "ready cycle", cnt, exp_states + exp_gap + 1);
      chk(first_a == a0, "R12", "first address", int'(first_a), int'(a0));
      chk(last_a == ((nbc == 2) ? {a0[23:1], 1'b1} : a0), "R5", "last address",
          int'(last_a), int'((nbc == 2) ? {a0[23:1], 1'b1} : a0));
      if (we) begin
         chk(wrc == exp_states - nbc, "R6", "write strobe states", wrc, exp_states - nbc);
         chk(rdc == 0, "R6", "no read strobe", rdc, 0);
         chk(cap == (word ? wd : {8'h00, wd[7:0]}), "R6", "write data", int'(cap),
             int'(word ? wd : {8'h00, wd[7:0]}));
      end else begin
         chk(rdc == exp_states, "R6", "read strobe states", rdc, exp_states);
         chk(req_rdata == exp_rd, "R4", "read data", int'(req_rdata), int'(exp_rd));
      end
      @(negedge clk);
      chk(!req_ready, "R4", "ready one cycle", int'(req_ready), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(ext_cs_n == 8'hFF, "R1", "reset selects", int'(ext_cs_n), 8'hFF);
      chk(ext_rd_n && ext_wr_n && !req_ready, "R1", "reset strobes/ready",
          int'({ext_rd_n, ext_wr_n, req_ready}), 3'b110);
      rst_n = 1'b1;
      @(negedge clk);
      // area0: wide, 3-state, 2 waits; area1: narrow 2-state wait 3; area2 wide 3-state; area3 narrow 3-state wait 1
      cw = 8'b0000_0101; c3 = 8'b0000_1101;
      cwt = 16'b0000_0000_0100_1110;
      ben = 1'b1; btwo = 1'b0; grr = 1'b1; grw = 1'b1;
      do_txn(1'b0, 1'b0, 24'h20_0005, 16'h0, "R2");          // R2 waits ignored
      do_txn(1'b0, 1'b1, 24'h40_0010, 16'h0, "R3");          // R3 wide word, gap R9
      do_txn(1'b0, 1'b1, 24'h00_0010, 16'h0, "R3");          // initial burst access
      do_txn(1'b0, 1'b1, 24'h00_0012, 16'h0, "R7");          // burst follow-on 1 state
      btwo = 1'b1;
      do_txn(1'b0, 1'b0, 24'h00_0015, 16'h0, "R7");          // burst follow-on 2 states
      do_txn(1'b0, 1'b1, 24'h00_0020, 16'h0, "R8");          // new block restarts
      do_txn(1'b1, 1'b1, 24'h00_0022, 16'hBEEF, "R10");      // write after read
      do_txn(1'b0, 1'b1, 24'h00_0024, 16'h0, "R8");          // write broke the burst
      do_txn(1'b0, 1'b1, 24'h60_0033, 16'h0, "R5");          // split, odd address R12
      do_txn(1'b0, 1'b0, 24'h20_0001, 16'h0, "R9");          // read other area
      do_txn(1'b0, 1'b0, 24'h20_0002, 16'h0, "R9");          // same area, no gap
      do_txn(1'b1, 1'b1, 24'h60_0040, 16'hA55A, "R5");       // split write
      do_txn(1'b1, 1'b0, 24'h40_0041, 16'h00C3, "R10");      // write after write
      for (int ph = 0; ph < 4; ph++) begin
         cw = 8'($urandom); c3 = 8'($urandom); cwt = 16'($urandom);
         ben = 1'($urandom); btwo = 1'($urandom);
         grr = 1'($urandom); grw = 1'($urandom);
         for (int n = 0; n < 70; n++) begin
            logic [2:0] ar;
            logic [5:0] off;
            ar = ($urandom % 3 == 0) ? 3'd0 : 3'($urandom);
            off = 6'($urandom % 48);
            do_txn(1'($urandom % 4 == 0), 1'($urandom), {ar, 15'd0, off},
                   16'($urandom), "R2/R3/R7/R8");
         end
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule